// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits in front of a paged memory write controller and watches each byte load (address plus data) that the host issues. It looks for two fixed command sequences: a three-load sequence that arms protection and a six-load sequence that removes it. It keeps a persistent protect flag. For every load it decides on the spot whether the byte may go on to the page buffer. When a protected page load closes without a preceding command sequence, it tells the controller to run a programming cycle that stores nothing.

Loads are grouped into page windows. A window opens on the first load and closes once `BLC_CYC` clock cycles pass with no further load. The controller then programs, and it reports the end of programming on `cycle_done_i`. A completed command sequence does not change the protect flag at once. The change is held as pending and applied at the next `cycle_done_i`, whether or not any data bytes followed the sequence. Only the low 15 address bits take part in matching.

Top module: `wp_cmd_guard`

## Requirements
- R1: After reset, protect_o is 0, dummy_o is 0, and pass_o is 0 while no load is presented.
- R2: The load sequence 0xAA at 0x5555, 0x55 at 0x2AAA, 0xA0 at 0x5555 (address bits 14:0 compared, higher bits ignored) sets protect_o to 1 in the cycle after the next cycle_done_i pulse.
- R3: The load sequence 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clears protect_o in the cycle after the next cycle_done_i pulse.
- R4: protect_o changes only on a cycle_done_i pulse. A completed sequence takes effect there even when no data byte followed it. A cycle_done_i pulse with nothing pending leaves it unchanged.
- R5: Every load that advances or completes a command sequence has pass_o = 0.
- R6: While unprotected, every load that is not consumed by a sequence has pass_o = 1, including loads to 0x5555 and 0x2AAA.
- R7: While protected, a data load has pass_o = 1 only if an enable or disable sequence completed earlier in the same window; otherwise pass_o = 0.
- R8: When a window closes while protected and without a completed sequence, dummy_o pulses high for exactly one cycle. Otherwise it stays low.
- R9: A load that is not the next expected command byte returns the matcher to idle and is judged as plain data under R6/R7.
- R10: A gap of BLC_CYC cycles with no load closes the window and discards a partial sequence. A gap of BLC_CYC-1 cycles keeps both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Byte load strobe, one cycle per byte |
| addr_i | input | ADDR_W | Load address |
| data_i | input | 8 | Load data |
| cycle_done_i | input | 1 | End-of-programming pulse from the write controller |
| protect_o | output | 1 | Current protect state |
| pass_o | output | 1 | Byte presented with load_i may be written |
| dummy_o | output | 1 | One-cycle pulse: run a programming cycle that writes nothing |

## Verification
All 256 data values are swept at the first command position and again at the second. This separates the single accepted byte at each step from every near miss, and checks that a rejected byte still passes as data. Enable, disable and mixed windows are run in both protect states. These show apart three things: a pending change versus an applied one, an unlocked window versus a suppressed one, and a dummy cycle versus an ordinary one. Inter-load gaps of exactly BLC_CYC-1 and BLC_CYC cycles pin down the window boundary on both sides. Upper address bits are set during an enable run to show that they are ignored.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;
  localparam int unsigned KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_LEAD  = 8'hAA;
  localparam logic [7:0] KEY_SECND = 8'h55;
  localparam logic [7:0] KEY_ARM   = 8'hA0;
  localparam logic [7:0] KEY_EXT   = 8'h80;
  localparam logic [7:0] KEY_DROP  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_X3,
    ST_X4,
    ST_X5
  } seq_st_e;
endpackage

// File: rtl/wp_load_window.sv
module wp_load_window #(
  parameter int unsigned BLC_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic open_o,
  output logic close_o
);
  localparam int unsigned CNT_W = $clog2(BLC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLC_CYC - 1);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  assign open_o  = open_q;
  assign close_o = open_q && !load_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (close_o) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (open_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> (cnt_q <= CNT_LAST));
  p_closed_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> !open_q);
endmodule

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_addr_i,
  input  logic [7:0]       data_i,
  input  logic             abort_i,
  output logic             consume_o,
  output logic             en_hit_o,
  output logic             dis_hit_o
);
  seq_st_e st_q, st_d;
  logic at_a, at_b;

  assign at_a = (key_addr_i == KEY_ADDR_A);
  assign at_b = (key_addr_i == KEY_ADDR_B);

  always_comb begin
    st_d      = st_q;
    consume_o = 1'b0;
    en_hit_o  = 1'b0;
    dis_hit_o = 1'b0;
    if (load_i) begin
      st_d = ST_IDLE;
      case (st_q)
        ST_IDLE: if (at_a && data_i == KEY_LEAD)  begin st_d = ST_K1; consume_o = 1'b1; end
        ST_K1:   if (at_b && data_i == KEY_SECND) begin st_d = ST_K2; consume_o = 1'b1; end
        ST_K2: begin
          if (at_a && data_i == KEY_ARM) begin
            consume_o = 1'b1;
            en_hit_o  = 1'b1;
          end else if (at_a && data_i == KEY_EXT) begin
            st_d      = ST_X3;
            consume_o = 1'b1;
          end
        end
        ST_X3:   if (at_a && data_i == KEY_LEAD)  begin st_d = ST_X4; consume_o = 1'b1; end
        ST_X4:   if (at_b && data_i == KEY_SECND) begin st_d = ST_X5; consume_o = 1'b1; end
        ST_X5: begin
          if (at_a && data_i == KEY_DROP) begin
            consume_o = 1'b1;
            dis_hit_o = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end else if (abort_i) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  p_abort_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (st_q == ST_IDLE));
  p_hit_restarts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_hit_o || dis_hit_o) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
  import wp_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned BLC_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              cycle_done_i,
  output logic              protect_o,
  output logic              pass_o,
  output logic              dummy_o
);
  logic win_open, win_close;
  logic consume, en_hit, dis_hit;
  logic protect_q, pend_en_q, pend_dis_q, unlock_q, dummy_q;
  logic unused_page;

  assign unused_page = ^addr_i[ADDR_W-1:KEY_W];

  wp_load_window #(.BLC_CYC(BLC_CYC)) win_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .open_o  (win_open),
    .close_o (win_close)
  );

  wp_seq_match match_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .key_addr_i (addr_i[KEY_W-1:0]),
    .data_i     (data_i),
    .abort_i    (win_close),
    .consume_o  (consume),
    .en_hit_o   (en_hit),
    .dis_hit_o  (dis_hit)
  );

  assign pass_o    = load_i && !consume && (!protect_q || unlock_q);
  assign protect_o = protect_q;
  assign dummy_o   = dummy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      protect_q  <= 1'b0;
      pend_en_q  <= 1'b0;
      pend_dis_q <= 1'b0;
      unlock_q   <= 1'b0;
      dummy_q    <= 1'b0;
    end else begin
      dummy_q <= win_close && protect_q && !unlock_q;
      if (win_close)               unlock_q <= 1'b0;
      else if (en_hit || dis_hit) unlock_q <= 1'b1;
      if (cycle_done_i) begin
        if (pend_en_q)       protect_q <= 1'b1;
        else if (pend_dis_q) protect_q <= 1'b0;
        pend_en_q  <= 1'b0;
        pend_dis_q <= 1'b0;
      end
      // a hit landing with cycle_done waits for the next cycle end
      if (en_hit) begin
        pend_en_q  <= 1'b1;
        pend_dis_q <= 1'b0;
      end else if (dis_hit) begin
        pend_dis_q <= 1'b1;
        pend_en_q  <= 1'b0;
      end
    end
  end

  p_protect_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_done_i |=> $stable(protect_q));
  p_rise_needs_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(protect_q) |-> $past(pend_en_q));
  p_fall_needs_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(protect_q) |-> $past(pend_dis_q));
  p_unlock_in_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_q |-> win_open);
  p_dummy_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_q |=> !dummy_q);
  p_dummy_after_close_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_q |-> !win_open || $past(load_i));
endmodule

// File: tb/wp_cmd_guard_tb.sv
module wp_cmd_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLC = 16;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, done = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  data = '0;
  logic protect, pass, dummy;
  int total = 0, bad = 0, dummy_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_cmd_guard #(.ADDR_W(17), .BLC_CYC(BLC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .addr_i(addr), .data_i(data),
    .cycle_done_i(done), .protect_o(protect), .pass_o(pass), .dummy_o(dummy)
  );

  always @(negedge clk) if (rst_n && dummy) dummy_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [16:0] a, input logic [7:0] d, input bit exp, input string req);
    @(negedge clk);
    load = 1'b1; addr = a; data = d;
    #1 chk(pass == exp, req, pass, exp);
    @(posedge clk);
    #1 load = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic cyc_done();
    @(negedge clk) done = 1'b1;
    @(posedge clk);
    #1 done = 1'b0;
  endtask

  task automatic chk_prot(input bit exp, input string req);
    @(negedge clk) chk(protect == exp, req, protect, exp);
  endtask

  task automatic chk_dummy(input int exp, input string req);
    @(negedge clk) chk(dummy_cnt == exp, req, dummy_cnt, exp);
  endtask

  task automatic arm(input logic [16:0] hi);
    do_load(hi | 17'h05555, 8'hAA, 1'b0, "R5");
    do_load(17'h02AAA, 8'h55, 1'b0, "R5");
    do_load(hi | 17'h05555, 8'hA0, 1'b0, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk);
    chk(protect == 1'b0, "R1", protect, 0);
    chk(pass == 1'b0, "R1", pass, 0);
    chk(dummy == 1'b0, "R1", dummy, 0);
    rst_n = 1'b1;

    // sweep first command position, unprotected
    for (int d = 0; d < 256; d++) begin
      do_load(17'h05555, 8'(d), d != 8'hAA, d == 8'hAA ? "R5" : "R9");
      if (d == 8'hAA) idle(BLC);
    end
    // sweep second command position
    for (int d = 0; d < 256; d++) begin
      do_load(17'h05555, 8'hAA, 1'b0, "R5");
      do_load(17'h02AAA, 8'(d), d != 8'h55, d == 8'h55 ? "R5" : "R9");
      idle(BLC);
    end
    chk_dummy(0, "R8");
    chk_prot(1'b0, "R9");

    // broken third byte: treated as data, no arming
    do_load(17'h05555, 8'hAA, 1'b0, "R5");
    do_load(17'h02AAA, 8'h55, 1'b0, "R5");
    do_load(17'h05555, 8'hA1, 1'b1, "R9");
    idle(BLC + 2);
    cyc_done();
    chk_prot(1'b0, "R9");
    do_load(17'h00100, 8'h12, 1'b1, "R6");
    do_load(17'h05555, 8'h00, 1'b1, "R6");
    idle(BLC + 2);
    cyc_done();
    chk_prot(1'b0, "R4");

    // arm with upper address bits set, plus one data byte
    arm(17'h10000);
    do_load(17'h00300, 8'h77, 1'b1, "R6");
    chk_prot(1'b0, "R4");
    idle(BLC + 2);
    chk_prot(1'b0, "R4");
    chk_dummy(0, "R8");
    cyc_done();
    chk_prot(1'b1, "R2");

    // protected, no command: suppressed, dummy cycle
    do_load(17'h00400, 8'h44, 1'b0, "R7");
    do_load(17'h05555, 8'h00, 1'b0, "R7");
    idle(BLC + 2);
    chk_dummy(1, "R8");
    cyc_done();
    chk_prot(1'b1, "R4");

    // protected, unlocked full page
    arm(17'h00000);
    for (int i = 0; i < 128; i++) do_load(17'h00A00 + 17'(i), 8'(i), 1'b1, "R7");
    idle(BLC + 2);
    chk_dummy(1, "R8");
    cyc_done();
    chk_prot(1'b1, "R4");

    // gap of BLC aborts the sequence
    do_load(17'h05555, 8'hAA, 1'b0, "R5");
    idle(BLC);
    do_load(17'h02AAA, 8'h55, 1'b0, "R10");
    do_load(17'h05555, 8'hA0, 1'b0, "R10");
    do_load(17'h00500, 8'h01, 1'b0, "R10");
    idle(BLC + 2);
    chk_dummy(3, "R10");
    cyc_done();

    // gap of BLC-1 keeps it
    do_load(17'h05555, 8'hAA, 1'b0, "R10");
    idle(BLC - 1);
    do_load(17'h02AAA, 8'h55, 1'b0, "R10");
    idle(BLC - 1);
    do_load(17'h05555, 8'hA0, 1'b0, "R10");
    do_load(17'h00600, 8'h09, 1'b1, "R10");
    idle(BLC + 2);
    chk_dummy(3, "R10");
    cyc_done();
    chk_prot(1'b1, "R4");

    // disable, no data bytes
    do_load(17'h05555, 8'hAA, 1'b0, "R5");
    do_load(17'h02AAA, 8'h55, 1'b0, "R5");
    do_load(17'h05555, 8'h80, 1'b0, "R5");
    do_load(17'h05555, 8'hAA, 1'b0, "R5");
    do_load(17'h02AAA, 8'h55, 1'b0, "R5");
    do_load(17'h05555, 8'h20, 1'b0, "R5");
    chk_prot(1'b1, "R4");
    idle(BLC + 2);
    chk_prot(1'b1, "R4");
    chk_dummy(3, "R8");
    cyc_done();
    chk_prot(1'b0, "R3");

    do_load(17'h00700, 8'h5A, 1'b1, "R6");
    idle(BLC + 2);
    chk_dummy(3, "R8");
    cyc_done();
    chk_prot(1'b0, "R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule